// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sits between a set of raw generated clocks and their output drivers. When the asynchronous active-low power-down input drops, it stops every clock. Each clock stops at a phase where stopping cuts no pulse short. Single-ended clocks are parked low. Differential pairs are parked with the true leg high and the complement leg low. Each pair also gets per-leg output enables that say which legs float in the parked state. Once every clock is parked, a flag tells the PLL control that the VCO may be shut down. When power-down is released, every clock restarts cleanly.

The raw clocks are treated as sampled level signals, all in the domain of one fast system clock `clk_i`. A rising edge of the reference complement clock is a cycle in which `diff_c_i[0]` is 1 after it was 0 in the previous cycle. The power-down pin passes through a two-stage synchronizer that advances only on those edges. A separate PCI stop bit parks the stoppable PCI outputs. The first `N_PCI_FREE` PCI outputs are free-running and ignore that bit. A per-clock enable bit from the register bank holds any single clock parked.

Top module: `clkstop_top`

## Requirements
- R1: The internal stop request rises only after `pd_ni` has been sampled low at two consecutive rising edges of `diff_c_i[0]`, where each sample passes through a two-stage synchronizer. A low level seen at only one such edge stops nothing.
- R2: While a single-ended clock is stopped, its output is held at 0. The output enters the stopped state only while its raw clock is low, so no high phase is shortened.
- R3: A stopped differential pair drives `diff_t_o`=1 and `diff_c_o`=0. A pair enters the stopped state only while its raw true leg is high.
- R4: Each pair has a drive-mode bit. When the bit is 0 (true driven), a stopped pair has `diff_oe_t_o`=1 and `diff_oe_c_o`=0. When the bit is 1 (float), a stopped pair has both enables at 0. A running pair has both enables at 1.
- R5: Every rising or falling edge on a gated output coincides with an edge of the same direction on its raw clock. This rules out runt pulses both when a clock stops and when it restarts.
- R6: PCI outputs with index below `N_PCI_FREE` ignore `pci_stop_ni`. The other PCI outputs are parked low while `pci_stop_ni`=0.
- R7: A parked pair that is allowed to run again is driven, with both enables at 1, within `DRIVE_LIMIT` cycles.
- R8: `vco_stop_o` is 1 only while the stop request is active and every output is parked. It clears in the same cycle that the synchronized power-down is released.
- R9: A clock whose enable bit is 0 stays parked whatever the state of power-down.
- R10: While `rst_ni`=0, all single-ended and PCI outputs are 0, every pair shows true=1, and `vco_stop_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Asynchronous power-down request, active low |
| pci_stop_ni | input | 1 | Stop request for the stoppable PCI outputs, active low |
| diff_t_i | input | N_DIFF | Raw true legs; bit 0 is the CPU pair |
| diff_c_i | input | N_DIFF | Raw complement legs; bit 0 qualifies power-down |
| diff_en_i | input | N_DIFF | Pair enables |
| diff_mode_i | input | N_DIFF | Stop drive mode per pair: 0 true driven, 1 float |
| se_clk_i | input | N_SE | Raw single-ended clocks |
| se_en_i | input | N_SE | Single-ended enables |
| pci_clk_i | input | 1 | Raw PCI clock |
| pci_en_i | input | N_PCI | PCI output enables |
| diff_t_o | output | N_DIFF | Gated true legs |
| diff_c_o | output | N_DIFF | Gated complement legs |
| diff_oe_t_o | output | N_DIFF | True-leg output enables |
| diff_oe_c_o | output | N_DIFF | Complement-leg output enables |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| vco_stop_o | output | 1 | All clocks parked; VCO may stop |

## Verification
The bench builds the block with two pairs, four single-ended clocks, four PCI outputs of which one is free-running, and `DRIVE_LIMIT`=6. The raw clocks use half periods of 2, 4, 3, 4, 5 and 7 cycles, so edges fall at every relative phase within a few dozen cycles. The bench places power-down pulses precisely against the reference complement edges, which makes the one-sample and two-sample qualification cases deterministic. It sweeps all four drive-mode combinations of the two pairs, and a per-cycle monitor checks that output edges only ever follow edges of the same direction on the raw clocks.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic {
    DRV_TRUE_HIGH = 1'b0,
    DRV_FLOAT     = 1'b1
  } drv_mode_e;
endpackage

// File: rtl/clkstop_qual.sv
module clkstop_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_ni,
  input  logic ref_c_i,
  output logic stop_req_o
);
  logic ref_q, sync1_q, sync2_q, hist_q;
  logic ref_rise;

  assign ref_rise = ref_c_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= 1'b0;
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      hist_q  <= 1'b1;
    end else begin
      ref_q <= ref_c_i;
      if (ref_rise) begin
        sync1_q <= pd_ni;
        sync2_q <= sync1_q;
        hist_q  <= sync2_q;
      end
    end
  end

  // two consecutive synchronized low samples
  assign stop_req_o = ~sync2_q & ~hist_q;

  a_r1_rise_on_ref_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_req_o) |-> $past(ref_rise));
  a_r1_fall_on_ref_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_req_o) |-> $past(ref_rise));
endmodule

// File: rtl/clkstop_se_gate.sv
module clkstop_se_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] run_i,
  output logic [N-1:0] clk_o,
  output logic [N-1:0] stopped_o
);
  logic [N-1:0] stopped_q;

  // state may change only during the raw low phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stopped_q <= '1;
    else         stopped_q <= (stopped_q & raw_i) | (~run_i & ~raw_i);
  end

  assign clk_o     = raw_i & ~stopped_q;
  assign stopped_o = stopped_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r2_parked_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[i] && !raw_i[i]) |=> !clk_o[i]);
    a_r5_rise_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_o[i]) |-> $rose(raw_i[i]));
    a_r5_fall_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_o[i]) |-> $fell(raw_i[i]));
  end
endmodule

// File: rtl/clkstop_diff_gate.sv
module clkstop_diff_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned N           = 2,
  parameter int unsigned DRIVE_LIMIT = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] t_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] run_i,
  input  logic [N-1:0] mode_i,
  output logic [N-1:0] t_o,
  output logic [N-1:0] c_o,
  output logic [N-1:0] oe_t_o,
  output logic [N-1:0] oe_c_o,
  output logic [N-1:0] stopped_o
);
  localparam int unsigned CW = $clog2(DRIVE_LIMIT + 1);

  logic [N-1:0] stopped_q;
  logic [N-1:0] float_m;

  // enter and leave only while the true leg is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stopped_q <= '1;
    else         stopped_q <= (stopped_q & ~t_i) | (~run_i & t_i);
  end

  for (genvar i = 0; i < N; i++) begin : g_pair
    assign float_m[i] = (drv_mode_e'(mode_i[i]) == DRV_FLOAT);

    logic [CW-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         wait_q <= '0;
      else if (!(run_i[i] && stopped_q[i])) wait_q <= '0;
      else if (wait_q != CW'(DRIVE_LIMIT)) wait_q <= wait_q + 1'b1;
    end

    a_r7_redrive_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q < CW'(DRIVE_LIMIT));
    a_r3_park_true_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(oe_c_o[i]) |-> ($past(t_o[i]) && t_o[i] && !c_o[i]));
    a_r4_float_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!oe_c_o[i] && float_m[i]) |-> !oe_t_o[i]);
    a_r5_true_rise_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(t_o[i]) |-> $rose(t_i[i]));
    a_r5_true_fall_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(t_o[i]) |-> $fell(t_i[i]));
  end

  assign t_o       = t_i | stopped_q;
  assign c_o       = c_i & ~stopped_q;
  assign oe_t_o    = ~(stopped_q & float_m);
  assign oe_c_o    = ~stopped_q;
  assign stopped_o = stopped_q;
endmodule

// File: rtl/clkstop_top.sv
module clkstop_top #(
  parameter int unsigned N_DIFF      = 2,
  parameter int unsigned N_SE        = 4,
  parameter int unsigned N_PCI       = 6,
  parameter int unsigned N_PCI_FREE  = 2,
  parameter int unsigned DRIVE_LIMIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              pci_stop_ni,
  input  logic [N_DIFF-1:0] diff_t_i,
  input  logic [N_DIFF-1:0] diff_c_i,
  input  logic [N_DIFF-1:0] diff_en_i,
  input  logic [N_DIFF-1:0] diff_mode_i,
  input  logic [N_SE-1:0]   se_clk_i,
  input  logic [N_SE-1:0]   se_en_i,
  input  logic              pci_clk_i,
  input  logic [N_PCI-1:0]  pci_en_i,
  output logic [N_DIFF-1:0] diff_t_o,
  output logic [N_DIFF-1:0] diff_c_o,
  output logic [N_DIFF-1:0] diff_oe_t_o,
  output logic [N_DIFF-1:0] diff_oe_c_o,
  output logic [N_SE-1:0]   se_clk_o,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic              vco_stop_o
);
  logic              stop_req;
  logic [N_SE-1:0]   se_stopped;
  logic [N_PCI-1:0]  pci_stopped, pci_run;
  logic [N_DIFF-1:0] diff_stopped;

  clkstop_qual u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_ni      (pd_ni),
    .ref_c_i    (diff_c_i[0]),
    .stop_req_o (stop_req)
  );

  clkstop_se_gate #(.N(N_SE)) u_se (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (se_clk_i),
    .run_i     (se_en_i & {N_SE{~stop_req}}),
    .clk_o     (se_clk_o),
    .stopped_o (se_stopped)
  );

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci_run
    if (i < N_PCI_FREE) begin : g_free
      assign pci_run[i] = pci_en_i[i] & ~stop_req;
    end else begin : g_stoppable
      assign pci_run[i] = pci_en_i[i] & ~stop_req & pci_stop_ni;
    end
  end

  clkstop_se_gate #(.N(N_PCI)) u_pci (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     ({N_PCI{pci_clk_i}}),
    .run_i     (pci_run),
    .clk_o     (pci_clk_o),
    .stopped_o (pci_stopped)
  );

  clkstop_diff_gate #(.N(N_DIFF), .DRIVE_LIMIT(DRIVE_LIMIT)) u_diff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .t_i       (diff_t_i),
    .c_i       (diff_c_i),
    .run_i     (diff_en_i & {N_DIFF{~stop_req}}),
    .mode_i    (diff_mode_i),
    .t_o       (diff_t_o),
    .c_o       (diff_c_o),
    .oe_t_o    (diff_oe_t_o),
    .oe_c_o    (diff_oe_c_o),
    .stopped_o (diff_stopped)
  );

  assign vco_stop_o = stop_req & (&se_stopped) & (&pci_stopped) & (&diff_stopped);

  a_r8_flag_all_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vco_stop_o |-> (se_clk_o == '0 && pci_clk_o == '0 && (&diff_t_o) && diff_oe_c_o == '0));
  a_r8_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stop_req) |-> !vco_stop_o);
  for (genvar i = 0; i < N_PCI_FREE; i++) begin : g_chk_free
    a_r6_free_ignores_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stop_req && pci_en_i[i] && !pci_clk_i) |=> !pci_stopped[i]);
  end
endmodule

// File: tb/tb_clkstop_top.sv
module tb_clkstop_top;
  localparam int ND = 2, NS = 4, NP = 4, NPF = 1, DL = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, pd_n, pci_stop_n, pci_raw;
  logic [ND-1:0] t_raw, c_raw, diff_en, diff_mode, t_o, c_o, oe_t, oe_c;
  logic [NS-1:0] se_raw, se_en, se_o;
  logic [NP-1:0] pci_en, pci_o;
  logic vco;
  int unsigned cyc = 0;
  int checks = 0, fails = 0, mon_fail = 0;
  bit mon_on = 0, done = 0;

  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic half_wave(int unsigned c, int unsigned h);
    return ((c / h) % 2) == 1;
  endfunction

  assign t_raw[0] = half_wave(cyc, 2);
  assign t_raw[1] = half_wave(cyc, 4);
  assign c_raw    = ~t_raw;
  assign se_raw   = {half_wave(cyc, 7), half_wave(cyc, 5), half_wave(cyc, 4), half_wave(cyc, 3)};
  assign pci_raw  = half_wave(cyc, 4);

  clkstop_top #(.N_DIFF(ND), .N_SE(NS), .N_PCI(NP), .N_PCI_FREE(NPF), .DRIVE_LIMIT(DL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pd_ni(pd_n), .pci_stop_ni(pci_stop_n),
    .diff_t_i(t_raw), .diff_c_i(c_raw), .diff_en_i(diff_en), .diff_mode_i(diff_mode),
    .se_clk_i(se_raw), .se_en_i(se_en), .pci_clk_i(pci_raw), .pci_en_i(pci_en),
    .diff_t_o(t_o), .diff_c_o(c_o), .diff_oe_t_o(oe_t), .diff_oe_c_o(oe_c),
    .se_clk_o(se_o), .pci_clk_o(pci_o), .vco_stop_o(vco));

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // R5 edge monitor: output edges must match raw edges of the same direction
  logic [NS-1:0] p_se_o, p_se_r;
  logic [NP-1:0] p_pci_o;
  logic p_pci_r;
  logic [ND-1:0] p_t_o, p_t_r;
  always @(negedge clk) begin
    #3;
    if (mon_on) begin
      for (int i = 0; i < NS; i++) begin
        if (se_o[i] && !p_se_o[i] && !(se_raw[i] && !p_se_r[i])) mon_fail++;
        if (!se_o[i] && p_se_o[i] && !(!se_raw[i] && p_se_r[i])) mon_fail++;
      end
      for (int i = 0; i < NP; i++) begin
        if (pci_o[i] && !p_pci_o[i] && !(pci_raw && !p_pci_r)) mon_fail++;
        if (!pci_o[i] && p_pci_o[i] && !(!pci_raw && p_pci_r)) mon_fail++;
      end
      for (int i = 0; i < ND; i++) begin
        if (t_o[i] && !p_t_o[i] && !(t_raw[i] && !p_t_r[i])) mon_fail++;
        if (!t_o[i] && p_t_o[i] && !(!t_raw[i] && p_t_r[i])) mon_fail++;
      end
    end
    p_se_o = se_o; p_se_r = se_raw; p_pci_o = pci_o; p_pci_r = pci_raw;
    p_t_o = t_o; p_t_r = t_raw;
  end

  // running outputs follow raw, disabled ones parked (R2, R3, R4, R6, R9)
  task automatic chk_follow(string tag);
    bit ok = 1;
    logic [NS-1:0] se_x;
    logic [NP-1:0] p_x;
    logic [ND-1:0] t_x, c_x;
    for (int k = 0; k < 16; k++) begin
      tick();
      se_x = se_raw & se_en;
      for (int i = 0; i < NP; i++) p_x[i] = pci_en[i] & pci_raw & ((i < NPF) | pci_stop_n);
      t_x = (t_raw & diff_en) | ~diff_en;
      c_x = c_raw & diff_en;
      if (se_o !== se_x || pci_o !== p_x || t_o !== t_x || c_o !== c_x ||
          oe_c !== diff_en || oe_t !== (diff_en | ~diff_mode) || vco !== 1'b0) begin
        if (ok) $display("FAIL %s cyc=%0d act=%0h/%0h/%0h exp=%0h/%0h/%0h",
                         tag, cyc, se_o, pci_o, t_o, se_x, p_x, t_x);
        ok = 0;
      end
    end
    checks++;
    if (!ok) fails++;
  endtask

  task automatic align_ref();
    while (cyc % 4 != 1) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp=0", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 0; pd_n = 1; pci_stop_n = 1;
    diff_en = '1; diff_mode = '0; se_en = '1; pci_en = '1;
    tick(5);
    // R10 reset state
    chk(se_o == '0, "R10 se outputs in reset", se_o, 0);
    chk(pci_o == '0, "R10 pci outputs in reset", pci_o, 0);
    chk(t_o == '1 && vco == 1'b0, "R10 true legs high, flag low", {t_o, vco}, {2'b11, 1'b0});
    rst_n = 1;
    tick(20);
    mon_on = 1;
    chk_follow("R4 R5 running after reset");

    // R1: low at one reference edge only
    begin
      bit stopped_seen = 0;
      align_ref(); pd_n = 0; tick(4); pd_n = 1;
      for (int k = 0; k < 30; k++) begin
        tick();
        if (vco || oe_c != '1) stopped_seen = 1;
      end
      chk(!stopped_seen, "R1 single low sample stops nothing", stopped_seen, 0);
    end
    // R1: low at two consecutive reference edges
    begin
      bit stopped_seen = 0;
      align_ref(); pd_n = 0; tick(8); pd_n = 1;
      for (int k = 0; k < 30; k++) begin
        tick();
        if (!oe_c[0]) stopped_seen = 1;
      end
      chk(stopped_seen, "R1 two low samples stop the CPU pair", stopped_seen, 1);
    end
    chk_follow("R5 running after short stop");

    // full power-down for every drive-mode combination
    for (int m = 0; m < 4; m++) begin
      int n_vco, n_oe;
      diff_mode = m[ND-1:0];
      tick(4);
      pd_n = 0;
      tick(60);
      chk(vco == 1'b1, "R8 flag set once parked", vco, 1);
      chk(se_o == '0, "R2 single-ended parked low", se_o, 0);
      chk(pci_o == '0, "R6 all pci parked in power-down", pci_o, 0);
      chk(t_o == '1 && c_o == '0, "R3 pairs park true high", {t_o, c_o}, {2'b11, 2'b00});
      chk(oe_t == ~diff_mode && oe_c == '0, "R4 leg enables per drive mode",
          {oe_t, oe_c}, {~diff_mode, 2'b00});
      pd_n = 1;
      n_vco = 0; n_oe = 0;
      while (vco && n_vco < 40) begin tick(); n_vco++; end
      chk(n_vco <= 9, "R8 flag clears on synchronized release", n_vco, 9);
      while (oe_c != '1 && n_oe < 40) begin tick(); n_oe++; end
      chk(oe_c == '1 && oe_t == '1 && n_oe <= DL + 1, "R7 pairs driven again in bound",
          n_oe, DL + 1);
      tick(16);
      chk_follow("R5 restart after power-down");
    end
    diff_mode = 2'b10;

    // R6 pci stop request
    pci_stop_n = 0;
    tick(12);
    chk_follow("R6 free pci runs, stoppable parked");
    pci_stop_n = 1;
    tick(12);
    chk_follow("R6 stoppable pci resume");

    // R9 disabled clocks stay parked through a power-down cycle
    se_en = 4'b1101; diff_en = 2'b01; pci_en = 4'b0111;
    tick(16);
    chk_follow("R9 disabled clocks parked");
    pd_n = 0; tick(50);
    chk(vco == 1'b1, "R8 flag with disabled clocks", vco, 1);
    pd_n = 1; tick(30);
    chk(se_o[1] == 1'b0 && oe_c[1] == 1'b0 && pci_o[3] == 1'b0,
        "R9 disabled clocks stay parked after release", {se_o[1], oe_c[1], pci_o[3]}, 0);
    chk_follow("R9 enabled clocks resume");
    se_en = '1; diff_en = '1; pci_en = '1;
    tick(16);
    chk_follow("R9 re-enabled clocks restart");

    chk(mon_fail == 0, "R5 no runt edge on any output", mon_fail, 0);
    summary();
  end
endmodule